// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit performs two operations that share one 32-bit permutation mask. A mask-set operation adds two 64-bit operands. It returns the 64-bit sum as its result and keeps the low 32 bits of that sum as the new mask. A shuffle operation treats its two 64-bit operands as a pool of sixteen bytes. Each byte of its 64-bit result is picked from that pool by one 4-bit field of the mask.

The permutation is therefore persistent state and not part of the operation. A mask-set programs it once, and any number of later shuffles reuse it. A shuffle issued in the cycle right after a mask-set already sees the new mask. Both operations return a registered result one cycle after the request strobe. The current mask can be read at any time on its own port.

Top module: `byte_shuffle_unit`

## Requirements
- R1: During reset and at its release, result_o, result_valid_o and mask_o are all zero.
- R2: A mask-set request (valid_i high, op_i = 0) yields result_o = a_i + b_i, taken modulo 2^64, at the clock edge that samples the request.
- R3: At that same edge, mask_o takes bits 31:0 of the sum a_i + b_i.
- R4: For a shuffle request (valid_i high, op_i = 1), result byte i (bits 8i+7:8i, i = 0..7) is chosen by mask field i (bits 4i+3:4i).
- R5: A mask field value n in 0..7 selects byte n of a_i. A value n in 8..15 selects byte n-8 of b_i.
- R6: A shuffle issued while the mask still holds its reset value returns byte 0 of a_i in all eight positions.
- R7: A shuffle issued in the cycle right after a mask-set uses the mask written by that mask-set.
- R8: result_valid_o is high for exactly one cycle after each accepted request and low after every cycle in which valid_i is low.
- R9: Shuffle requests and idle cycles leave mask_o unchanged. Idle cycles also leave result_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 1 | Operation select: 0 = mask-set, 1 = shuffle |
| a_i | input | 64 | First operand (pool bytes 0..7) |
| b_i | input | 64 | Second operand (pool bytes 8..15) |
| result_o | output | 64 | Registered result |
| result_valid_o | output | 1 | Result strobe, one cycle after the request |
| mask_o | output | 32 | Current permutation mask |

## Verification
The hardest case to reach is a shuffle that consumes a mask written in the cycle just before it. The stimulus issues a mask-set and a shuffle on consecutive cycles, with no idle cycle between them. It also runs a shuffle before any mask-set, which covers the reset mask. Cross-operand masks interleave bytes of a_i and b_i in a scrambled order, so a selector that ignores the top field bit or swaps the operands gives a visibly wrong result. A behavioural model is compared with every output on every clock, alongside the directed checks.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic {
    OP_SETMASK = 1'b0,
    OP_SHUFFLE = 1'b1
  } bsu_op_e;
endpackage

// File: rtl/bsu_mask_add.sv
module bsu_mask_add #(
  parameter int DATA_W = 64,
  parameter int MASK_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [MASK_W-1:0] mask_o
);
  always_comb begin
    sum_o  = a_i + b_i;
    mask_o = sum_o[MASK_W-1:0];
  end
endmodule

// File: rtl/bsu_byte_sel.sv
module bsu_byte_sel #(
  parameter int LANE_W  = 8,
  parameter int N_LANES = 8,
  localparam int POOL_N = 2 * N_LANES,
  localparam int SEL_W  = $clog2(POOL_N)
) (
  input  logic [POOL_N*LANE_W-1:0] pool_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [LANE_W-1:0]        lane_o
);
  logic [LANE_W-1:0] lanes [POOL_N];

  for (genvar k = 0; k < POOL_N; k++) begin : g_lane
    assign lanes[k] = pool_i[k*LANE_W +: LANE_W];
  end

  assign lane_o = lanes[sel_i];
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int N_LANES = DATA_W / LANE_W,
  localparam int SEL_W   = $clog2(2 * N_LANES),
  localparam int MASK_W  = N_LANES * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [MASK_W-1:0] mask_o
);
  import bsu_pkg::*;

  bsu_op_e           op;
  logic [DATA_W-1:0] sum;
  logic [MASK_W-1:0] new_mask;
  logic [DATA_W-1:0] shuf;
  logic [DATA_W-1:0] result_d;
  logic [DATA_W-1:0] result_q;
  logic [MASK_W-1:0] mask_q;
  logic              valid_q;

  assign op = bsu_op_e'(op_i);

  bsu_mask_add #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_add (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum),
    .mask_o(new_mask)
  );

  // mask is written at the same edge as the set result, so a following shuffle sees it directly
  for (genvar i = 0; i < N_LANES; i++) begin : g_sel
    bsu_byte_sel #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_sel (
      .pool_i(({b_i, a_i})),
      .sel_i (mask_q[i*SEL_W +: SEL_W]),
      .lane_o(shuf[i*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    result_d = result_q;
    if (valid_i) result_d = (op == OP_SETMASK) ? sum : shuf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      mask_q   <= '0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_i;
      if (valid_i && op == OP_SETMASK) mask_q <= new_mask;
    end
  end

  assign result_o       = result_q;
  assign result_valid_o = valid_q;
  assign mask_o         = mask_q;
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int DATA_W = 64,
  parameter int MASK_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic [MASK_W-1:0] mask_o
);
  logic [DATA_W-1:0] sum_in;
  assign sum_in = a_i + b_i;

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_valid_o);

  // R8
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !result_valid_o);

  // R2
  set_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i) |=> (result_o == $past(sum_in)));

  // R3
  set_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i) |=> (mask_o == $past(sum_in[MASK_W-1:0])));

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !op_i) |=> $stable(mask_o));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

bind byte_shuffle_unit bsu_checker #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .op_i          (op_i),
  .a_i           (a_i),
  .b_i           (b_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .mask_o        (mask_o)
);

// File: tb/sim_byte_shuffle_unit.sv
module sim_byte_shuffle_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        op = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic [63:0] result;
  logic        result_valid;
  logic [31:0] mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] A_PAT = 64'h8877665544332211;
  localparam logic [63:0] B_PAT = 64'hFFEEDDCCBBAA9988;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_shuffle_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .result_o(result), .result_valid_o(result_valid), .mask_o(mask)
  );

  // reference model
  logic [63:0] m_res = '0;
  logic        m_valid = 1'b0;
  logic [31:0] m_mask = '0;
  logic        m_last_shuf = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = '0; m_valid = 1'b0; m_mask = '0; m_last_shuf = 1'b0;
    end else begin
      m_valid = valid;
      if (valid) begin
        if (!op) begin
          m_res = a + b;
          m_mask = m_res[31:0];
          m_last_shuf = 1'b0;
        end else begin
          logic [63:0] r;
          r = '0;
          for (int i = 0; i < 8; i++) begin
            int n;
            n = (m_mask >> (4*i)) & 15;
            if (n < 8) r[8*i +: 8] = a[8*n +: 8];
            else       r[8*i +: 8] = b[8*(n-8) +: 8];
          end
          m_res = r;
          m_last_shuf = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (result_valid !== m_valid) begin
        errors++;
        $display("FAIL R8 model valid act=%0b exp=%0b", result_valid, m_valid);
      end
      checks++;
      if (mask !== m_mask) begin
        errors++;
        $display("FAIL R3 model mask act=%h exp=%h", mask, m_mask);
      end
      checks++;
      if (result !== m_res) begin
        errors++;
        if (m_last_shuf) $display("FAIL R4 model result act=%h exp=%h", result, m_res);
        else             $display("FAIL R2 model result act=%h exp=%h", result, m_res);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drives at a negedge, returns at the next negedge with the result visible
  task automatic issue(logic o, logic [63:0] x, logic [63:0] y);
    valid = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", result, '0);
    chk("R1 valid", {63'b0, result_valid}, '0);
    chk("R1 mask", {32'b0, mask}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'b0, result_valid, mask}, '0);

    // R6 shuffle with reset mask
    issue(1'b1, A_PAT, B_PAT);
    chk("R6 broadcast", result, 64'h1111111111111111);
    chk("R8 valid", {63'b0, result_valid}, 64'd1);

    // R2 R3 wrap-around sum, identity mask
    issue(1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000076543211);
    chk("R2 sum", result, 64'h0000000076543210);
    chk("R3 mask", {32'b0, mask}, 64'h76543210);

    // R4 identity
    issue(1'b1, A_PAT, B_PAT);
    chk("R4 identity", result, A_PAT);

    // R4 reverse
    issue(1'b0, 64'd0, 64'h01234567);
    issue(1'b1, A_PAT, B_PAT);
    chk("R4 reverse", result, 64'h1122334455667788);

    // R5 cross-operand interleave
    issue(1'b0, 64'd0, 64'h0F1E2D3C);
    issue(1'b1, A_PAT, B_PAT);
    chk("R5 cross", result, 64'h11FF22EE33DD44CC);

    // R7 back-to-back set then shuffle
    valid = 1'b1; op = 1'b0; a = '0; b = 64'hFEDCBA98;
    @(negedge clk);
    op = 1'b1; a = A_PAT; b = B_PAT;
    @(negedge clk);
    valid = 1'b0;
    chk("R7 forwarded mask", result, B_PAT);
    chk("R9 mask after shuffle", {32'b0, mask}, 64'hFEDCBA98);

    // R9 idle hold, R8 strobe drop
    a = '1; b = '1;
    repeat (3) @(negedge clk);
    chk("R9 result hold", result, B_PAT);
    chk("R9 mask hold", {32'b0, mask}, 64'hFEDCBA98);
    chk("R8 valid low", {63'b0, result_valid}, '0);

    // R5 high half of b only via all-upper fields
    issue(1'b0, 64'd0, 64'hFFFFEEEE);
    issue(1'b1, A_PAT, B_PAT);
    chk("R5 upper b", result, 64'hFFFFFFFFEEEEEEEE);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule